// File: doc/BRIEF.md
# Hybrid Priority / Round-Robin Channel Arbiter

This block chooses which of `N_CH` requesting channels gets the shared DMA engine in each arbitration cycle. Channels are numbered from 1 upward; channel *k* drives bit *k−1* of the request vector. A 2-bit mode input puts the lowest-numbered channels into a fixed-priority group. The group holds 0, 3, 16 or 64 channels. A requesting channel in the group always wins, and the lowest-numbered one wins among them. All channels above the group take turns in round-robin order, which a registered pointer tracks.

The grant is combinational from the request vector, the mode and the stored pointer. A consumer takes the grant by raising the accept strobe. The pointer then moves on the next clock edge, but only if the accepted channel is a round-robin channel. Receive and transmit traffic can each use their own instance, each with its own mode.

Top module: `hybrid_arb`

## Requirements
- R1: With no request bit set, `gnt_vld_o` is 0 and `gnt_o` is all zeros, both during reset and after it. After reset the round-robin pointer starts at the first channel above the group.
- R2: The mode sets the group size. 2'b00 gives no group, 2'b01 gives channels 1–3 (bits 0–2), 2'b10 gives channels 1–16 (bits 0–15) and 2'b11 gives channels 1–64 (bits 0–63).
- R3: When several group channels request, the lowest-numbered one is granted.
- R4: Any requesting group channel is granted ahead of every requesting round-robin channel.
- R5: With no group request, the grant goes to the first requesting round-robin channel at or above the pointer. If there is none, the search wraps to the lowest requesting round-robin channel.
- R6: An accepted round-robin grant moves the pointer to one past the granted channel. An accepted grant on the highest channel moves the pointer back to the first channel above the group.
- R7: While accept is low, the pointer holds its value, so unchanged requests and mode give an unchanged grant.
- R8: An accepted grant to a group channel leaves the pointer unchanged.
- R9: A mode change takes effect in the same cycle. If the pointer falls inside the new group, it is moved to the first channel above the group and stays there after the mode changes again.
- R10: When `gnt_vld_o` is 1, `gnt_o` has exactly one bit set, that bit is bit `gnt_idx_o` (channel number minus one), and that channel is requesting. Any request gives a valid grant.
- R11: The grant follows a change of request or mode in the same cycle, with no register between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | N_CH | Request vector, bit k−1 is channel k |
| mode_i | input | 2 | Priority group size select |
| accept_i | input | 1 | Consumer takes the current grant |
| gnt_o | output | N_CH | One-hot grant |
| gnt_idx_o | output | $clog2(N_CH) | Granted bit index (channel − 1) |
| gnt_vld_o | output | 1 | A grant is present |

## Verification
Grant, index and valid depend only on the present inputs and the stored pointer. The bench therefore drives new inputs at the falling edge and compares the outputs 1 ns later, before any rising edge has passed. The effect of accept appears only after the next rising edge, so the bench updates its own pointer model after each comparison. The following call, one cycle later, then checks the moved pointer. Mode changes are checked the same way: in the cycle they are applied for the grant, and in later cycles for the stored pointer.

// File: rtl/hpa_pkg.sv
// Package: shared types for the hybrid priority / round-robin arbiter.
// Assumes: the mode field is two bits wide and encodes the group size.
package hpa_pkg;

    typedef enum logic [1:0] {
        MODE_ALL_RR = 2'b00,
        MODE_GRP_S  = 2'b01,
        MODE_GRP_M  = 2'b10,
        MODE_GRP_L  = 2'b11
    } arb_mode_e;

endpackage

// File: rtl/hpa_grp_decode.sv
// Module: turns the mode into a group size and a per-channel group mask.
// Assumes: GRP_L < N_CH, so the round-robin region is never empty.
module hpa_grp_decode
    import hpa_pkg::*;
#(
    parameter int N_CH  = 128,
    parameter int GRP_S = 3,
    parameter int GRP_M = 16,
    parameter int GRP_L = 64,
    parameter int IDXW  = $clog2(N_CH)
) (
    input  logic [1:0]      mode_i,
    output logic [IDXW-1:0] grp_size_o,
    output logic [N_CH-1:0] grp_mask_o
);

    // Map the mode encoding onto a group size.
    always_comb begin
        unique case (arb_mode_e'(mode_i))
            MODE_GRP_S: grp_size_o = IDXW'(GRP_S);
            MODE_GRP_M: grp_size_o = IDXW'(GRP_M);
            MODE_GRP_L: grp_size_o = IDXW'(GRP_L);
            default:    grp_size_o = '0;
        endcase
    end

    // One mask bit per channel: set when the channel is below the group size.
    for (genvar i = 0; i < N_CH; i++) begin : g_mask
        assign grp_mask_o[i] = (IDXW'(i) < grp_size_o);
    end

endmodule

// File: rtl/hpa_lsb_find.sv
// Module: finds the lowest set bit of a vector and reports its position.
// Assumes: IW bits are enough to hold W-1.
module hpa_lsb_find #(
    parameter int W  = 128,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);

    // Scan from the top down so the lowest set bit is written last.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/hpa_rr_ptr.sv
// Module: round-robin pointer register with clamping to the round-robin region.
// Assumes: grp_size_i < N_CH; adv_i is raised only for an accepted round-robin grant.
module hpa_rr_ptr #(
    parameter int N_CH = 128,
    parameter int IDXW = $clog2(N_CH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IDXW-1:0] grp_size_i,
    input  logic            adv_i,
    input  logic [IDXW-1:0] gnt_idx_i,
    output logic [IDXW-1:0] ptr_eff_o
);

    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(N_CH - 1);

    logic [IDXW-1:0] ptr_q;
    logic [IDXW-1:0] ptr_next;

    // A pointer inside the group acts as the first channel above it.
    assign ptr_eff_o = (ptr_q < grp_size_i) ? grp_size_i : ptr_q;

    // Next pointer: one past the grant, wrapping to the group edge; else the clamped value.
    always_comb begin
        if (adv_i) begin
            ptr_next = (gnt_idx_i == LAST_IDX) ? grp_size_i : gnt_idx_i + IDXW'(1);
        end else begin
            ptr_next = ptr_eff_o;
        end
    end

    // Pointer register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_next;
    end

endmodule

// File: rtl/hybrid_arb.sv
// Module: hybrid arbiter. A fixed-priority group of the lowest channels, chosen by the
// mode, always wins; the channels above it share in round-robin order.
// Assumes: 1-based channels on 0-based bits; GRP_L < N_CH; the grant is combinational.
module hybrid_arb #(
    parameter int N_CH  = 128,
    parameter int GRP_S = 3,
    parameter int GRP_M = 16,
    parameter int GRP_L = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_CH-1:0]         req_i,
    input  logic [1:0]              mode_i,
    input  logic                    accept_i,
    output logic [N_CH-1:0]         gnt_o,
    output logic [$clog2(N_CH)-1:0] gnt_idx_o,
    output logic                    gnt_vld_o
);

    localparam int IDXW = $clog2(N_CH);

    logic [IDXW-1:0] grp_size;
    logic [N_CH-1:0] grp_mask;
    logic [IDXW-1:0] ptr_eff;
    logic [N_CH-1:0] upper_mask;
    logic [N_CH-1:0] pri_req, rr_all_req, rr_hi_req;
    logic            pri_found, hi_found, all_found;
    logic [IDXW-1:0] pri_idx, hi_idx, all_idx;
    logic            rr_adv;

    hpa_grp_decode #(
        .N_CH(N_CH), .GRP_S(GRP_S), .GRP_M(GRP_M), .GRP_L(GRP_L), .IDXW(IDXW)
    ) grp_dec_i (
        .mode_i     (mode_i),
        .grp_size_o (grp_size),
        .grp_mask_o (grp_mask)
    );

    hpa_rr_ptr #(.N_CH(N_CH), .IDXW(IDXW)) ptr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .grp_size_i (grp_size),
        .adv_i      (rr_adv),
        .gnt_idx_i  (gnt_idx_o),
        .ptr_eff_o  (ptr_eff)
    );

    // Mask of channels at or above the effective pointer.
    for (genvar i = 0; i < N_CH; i++) begin : g_upper
        assign upper_mask[i] = (IDXW'(i) >= ptr_eff);
    end

    // Split the requests into group, whole round-robin region and region above the pointer.
    assign pri_req    = req_i & grp_mask;
    assign rr_all_req = req_i & ~grp_mask;
    assign rr_hi_req  = rr_all_req & upper_mask;

    hpa_lsb_find #(.W(N_CH), .IW(IDXW)) pri_find_i (
        .vec_i(pri_req), .found_o(pri_found), .idx_o(pri_idx)
    );
    hpa_lsb_find #(.W(N_CH), .IW(IDXW)) hi_find_i (
        .vec_i(rr_hi_req), .found_o(hi_found), .idx_o(hi_idx)
    );
    hpa_lsb_find #(.W(N_CH), .IW(IDXW)) all_find_i (
        .vec_i(rr_all_req), .found_o(all_found), .idx_o(all_idx)
    );

    // Pick the winner: group first, then above the pointer, then the wrapped search.
    always_comb begin
        if (pri_found)      gnt_idx_o = pri_idx;
        else if (hi_found)  gnt_idx_o = hi_idx;
        else                gnt_idx_o = all_idx;
    end

    assign gnt_vld_o = pri_found | all_found;

    // Only an accepted round-robin grant moves the pointer.
    assign rr_adv = accept_i & gnt_vld_o & ~pri_found;

    // Decode the index into the one-hot grant vector.
    for (genvar i = 0; i < N_CH; i++) begin : g_onehot
        assign gnt_o[i] = gnt_vld_o && (gnt_idx_o == IDXW'(i));
    end

endmodule

// File: rtl/hybrid_arb_chk.sv
// Module: property checker for hybrid_arb, attached by bind.
// Assumes: the same group-size parameters as the arbiter it watches.
module hybrid_arb_chk #(
    parameter int N_CH  = 128,
    parameter int GRP_S = 3,
    parameter int GRP_M = 16,
    parameter int GRP_L = 64,
    parameter int IDXW  = $clog2(N_CH)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N_CH-1:0] req_i,
    input logic [1:0]      mode_i,
    input logic            accept_i,
    input logic [N_CH-1:0] gnt_o,
    input logic [IDXW-1:0] gnt_idx_o,
    input logic            gnt_vld_o
);

    logic [IDXW-1:0] spec_gsz;
    logic            req_in_grp;
    logic            req_below_idx;

    // Group size taken straight from the mode encoding.
    always_comb begin
        case (mode_i)
            2'b01:   spec_gsz = IDXW'(GRP_S);
            2'b10:   spec_gsz = IDXW'(GRP_M);
            2'b11:   spec_gsz = IDXW'(GRP_L);
            default: spec_gsz = '0;
        endcase
    end

    // Any request inside the group; any request below the granted index.
    always_comb begin
        req_in_grp    = 1'b0;
        req_below_idx = 1'b0;
        for (int i = 0; i < N_CH; i++) begin
            if (req_i[i] && IDXW'(i) < spec_gsz)  req_in_grp    = 1'b1;
            if (req_i[i] && IDXW'(i) < gnt_idx_o) req_below_idx = 1'b1;
        end
    end

    // R1
    idle_no_grant_chk: assert property (@(posedge clk)
        (req_i == '0) |-> (!gnt_vld_o && gnt_o == '0));

    // R10
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_vld_o |-> ($countones(gnt_o) == 1 && gnt_o[gnt_idx_o] && req_i[gnt_idx_o]));

    // R10
    request_served_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i != '0) |-> gnt_vld_o);

    // R4
    group_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_vld_o && gnt_idx_o >= spec_gsz) |-> !req_in_grp);

    // R3
    group_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_vld_o && gnt_idx_o < spec_gsz) |-> !req_below_idx);

    // R7
    hold_without_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(accept_i) && $stable(req_i) && $stable(mode_i)) |-> $stable(gnt_idx_o));

endmodule

bind hybrid_arb hybrid_arb_chk #(
    .N_CH(N_CH), .GRP_S(GRP_S), .GRP_M(GRP_M), .GRP_L(GRP_L), .IDXW($clog2(N_CH))
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_i),
    .mode_i    (mode_i),
    .accept_i  (accept_i),
    .gnt_o     (gnt_o),
    .gnt_idx_o (gnt_idx_o),
    .gnt_vld_o (gnt_vld_o)
);

// File: tb/hybrid_arb_tb_top.sv
// Bench: sweeps a 68-channel arbiter against an arithmetic model of the requirements.
module hybrid_arb_tb_top;

    localparam int N  = 68;
    localparam int IW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req = '0;
    logic [1:0]    mode = 2'b00;
    logic          acc = 1'b0;
    logic [N-1:0]  gnt;
    logic [IW-1:0] gnt_idx;
    logic          gnt_vld;

    int  tests = 0;
    int  fails = 0;
    int  mptr  = 0;
    bit  done  = 0;

    always #2 clk = ~clk;

    hybrid_arb #(.N_CH(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req), .mode_i(mode), .accept_i(acc),
        .gnt_o(gnt), .gnt_idx_o(gnt_idx), .gnt_vld_o(gnt_vld)
    );

    function automatic int gsz_of(input int m);
        case (m)
            1:       return 3;
            2:       return 16;
            3:       return 64;
            default: return 0;
        endcase
    endfunction

    function automatic void predict(input logic [N-1:0] r, input int m, input int p,
                                    output int idx, output bit v);
        int g   = gsz_of(m);
        int eff = (p < g) ? g : p;
        v = 0; idx = 0;
        for (int i = 0; i < g; i++)   if (!v && r[i]) begin v = 1; idx = i; end
        for (int i = eff; i < N; i++) if (!v && r[i]) begin v = 1; idx = i; end
        for (int i = g; i < eff; i++) if (!v && r[i]) begin v = 1; idx = i; end
    endfunction

    // Drive at the falling edge, compare 1 ns later, then advance the pointer model.
    task automatic apply(input logic [N-1:0] r, input int m, input bit a, input string tag);
        int         eidx;
        bit         ev;
        logic [N-1:0] egnt;
        int         g;
        @(negedge clk);
        req = r; mode = 2'(m); acc = a;
        #1;
        predict(r, m, mptr, eidx, ev);
        egnt = '0;
        if (ev) egnt[eidx] = 1'b1;
        tests++;
        if (gnt_vld !== ev || gnt !== egnt || (ev && int'(gnt_idx) != eidx)) begin
            fails++;
            $display("FAIL %s: vld=%0b idx=%0d gnt=%h expected vld=%0b idx=%0d gnt=%h",
                     tag, gnt_vld, gnt_idx, gnt, ev, eidx, egnt);
        end
        g = gsz_of(m);
        if (a && ev && eidx >= g) mptr = (eidx == N - 1) ? g : eidx + 1;
        else if (mptr < g)        mptr = g;
    endtask

    function automatic logic [N-1:0] bit_at(input int i);
        logic [N-1:0] v = '0;
        v[i] = 1'b1;
        return v;
    endfunction

    initial begin
        logic [N-1:0] rr_only;
        // R1: idle during reset
        repeat (2) @(negedge clk);
        #1;
        tests++;
        if (gnt_vld !== 1'b0 || gnt !== '0) begin
            fails++;
            $display("FAIL R1: vld=%0b gnt=%h expected vld=0 gnt=0", gnt_vld, gnt);
        end
        @(negedge clk); rst_n = 1'b1;

        // R1: idle after reset, every mode
        for (int m = 0; m < 4; m++) apply('0, m, 1'b1, "R1 idle");

        // R2/R10/R11: single request on every channel in every mode
        for (int m = 0; m < 4; m++)
            for (int i = 0; i < N; i++) apply(bit_at(i), m, 1'b0, "R10 R11 single");

        // R2: group edges for each mode
        apply(bit_at(2) | bit_at(3), 1, 1'b0, "R2 edge 3/4");
        apply(bit_at(15) | bit_at(16), 2, 1'b0, "R2 edge 16/17");
        apply(bit_at(63) | bit_at(64), 3, 1'b0, "R2 edge 64/65");
        apply(bit_at(63) | bit_at(64) | bit_at(2), 0, 1'b0, "R2 no group");

        // R3: pairs inside the largest group
        for (int a = 0; a < 64; a++) apply(bit_at(a) | bit_at((a * 11 + 7) % 64), 3, 1'b0, "R3 pair");

        // R4: group request against round-robin requests, each mode
        for (int m = 1; m < 4; m++)
            for (int i = 0; i < N; i++)
                apply(bit_at(i) | bit_at(N - 1) | bit_at(gsz_of(m)), m, 1'b0, "R4 mix");

        // R5/R6: full rotation in mode 01 over every round-robin channel, with wrap
        rr_only = '1;
        rr_only[2:0] = 3'b000;
        for (int k = 0; k < N; k++) apply(rr_only, 1, 1'b1, "R6 rotate");
        apply(bit_at(10) | bit_at(5), 1, 1'b0, "R5 wrap search");

        // R8: accepted group grants leave the pointer in place
        for (int k = 0; k < 4; k++) apply('1, 1, 1'b1, "R8 group accept");
        apply(rr_only, 1, 1'b0, "R8 pointer kept");

        // R7: no accept keeps the grant
        for (int k = 0; k < 5; k++) apply(bit_at(10) | bit_at(30) | bit_at(50), 0, 1'b0, "R7 hold");

        // R9: pointer at 10 in mode 00, clamped by mode 10, then seen again in mode 00
        apply(bit_at(9), 0, 1'b1, "R9 set pointer");
        apply(bit_at(5), 2, 1'b0, "R9 mode switch");
        apply(bit_at(12) | bit_at(5), 0, 1'b0, "R9 clamp kept");

        // R5/R6/R9: pseudo-random requests, accepts and mode changes
        for (int k = 0; k < 3000; k++) begin
            logic [N-1:0] r;
            int m;
            r = {$urandom(), $urandom(), $urandom()};
            if (k % 3 == 0) r = r & {$urandom(), $urandom(), $urandom()};
            m = (k % 16 == 0) ? int'($urandom() % 4) : int'(mode);
            apply(r, m, 1'($urandom() % 2), "R5 R6 R9 random");
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule